// File: doc/BRIEF.md
# Flash Operation Timing Sequencer

This block times the long-running operations of an embedded NOR flash macro. A register front end, which is not part of this block, decodes the control register write into five one-hot command bits: mass erase, page erase, program, reference-cell erase and trim recall. When the sequencer is idle it takes the write and picks one command by fixed priority. It then runs that command for a number of clock cycles taken from three packed timing words.

Erase and program commands have two phases. A main pulse phase lasts for the erase or program count. A non-volatile hold phase follows it and lasts for the hold count. Trim recall has one short phase, timed by the cycles-per-100-ns field. The busy status bit stays high for the whole operation, and a per-command clear pulse tells the register front end to drop the command bit. Phase enables, the active command and the selected page index go to the array model.

Top module: `flash_op_seq`

## Requirements
- R1: After synchronous reset, busy (status bit 0), op_active, main_en, hold_en and op_clear are all zero.
- R2: A cycle with ctl_wr high, at least one ctl_ops bit set and busy low starts a command, and busy is high from the next cycle on. A write with no ctl_ops bit set starts nothing.
- R3: Command bits are ctl_ops[0] mass erase, [1] page erase, [2] program, [3] reference-cell erase and [4] trim recall. When several bits are set, the lowest set index wins. op_active shows the chosen command as one-hot while busy.
- R4: Program keeps main_en high for max(tim2[15:0],1) cycles, then hold_en high for max(tim0[31:16],1) cycles. Busy spans exactly their sum.
- R5: Mass, page and reference-cell erase keep main_en high for max(tim1[23:0],1) cycles, then hold_en high for max(tim0[31:16],1) cycles.
- R6: Trim recall keeps main_en high for max(tim2[23:16],1) cycles and has no hold phase.
- R7: A zero count field makes its phase last exactly one cycle.
- R8: A command written while busy is ignored. The running command, its remaining duration and its identity are unchanged, and nothing starts after it ends.
- R9: Timing fields are captured when a command starts. Changing tim0, tim1 or tim2 during the operation does not change its duration.
- R10: In the first cycle after busy falls, op_clear carries the finished command's bit for exactly one cycle. It is zero otherwise.
- R11: page_idx shows the start-time addr divided by the 4096-byte page size (addr[ADDR_W-1:12]) and holds until the next command.
- R12: status is {brownout, discharged, redundancy-disabled, 0, busy} for bits 4 to 0.
- R13: read_wait equals tim0[5:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_ops | input | 5 | Decoded command bits |
| tim0 | input | 32 | Hold count [31:16], read wait states [5:0] |
| tim1 | input | 32 | Erase count [23:0] |
| tim2 | input | 32 | Cycles per 100 ns [23:16], program count [15:0] |
| addr | input | ADDR_W | Erase/program byte address |
| redun_dis | input | 1 | Redundancy-disabled flag |
| discharged | input | 1 | Discharged flag |
| brownout | input | 1 | Brown-out flag |
| status | output | 5 | Status bits, busy at bit 0 |
| op_active | output | 5 | One-hot command in progress |
| main_en | output | 1 | Main pulse phase enable |
| hold_en | output | 1 | Non-volatile hold phase enable |
| op_clear | output | 5 | One-cycle clear of the finished command bit |
| page_idx | output | ADDR_W-12 | Selected page |
| read_wait | output | 6 | Read wait states |

## Verification
The bench measures the length of each phase for every command type. A design that swapped the erase and program counts, or that dropped the hold phase, would show the wrong main or hold length. It drives zero count fields, where an unguarded down-counter would wrap and run for millions of cycles. It also sets several command bits at once, and a wrong priority would start the wrong command. During an operation the bench writes a new command and rewrites all timing words. A design that restarted or reloaded would stretch busy or change op_active. The bench fills unused high bits with noise, so a field sliced at the wrong position changes the measured lengths.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam int NUM_OPS    = 5;
    localparam int OPI_MASS   = 0;
    localparam int OPI_PAGE   = 1;
    localparam int OPI_PROG   = 2;
    localparam int OPI_REF    = 3;
    localparam int OPI_RECALL = 4;

    localparam int REG_W   = 32;
    localparam int HOLD_W  = 16;
    localparam int ERASE_W = 24;
    localparam int PROG_W  = 16;
    localparam int SHORT_W = 8;
    localparam int RWAIT_W = 6;
    localparam int CNT_W   = ERASE_W;

    typedef logic [NUM_OPS-1:0] op_vec_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_MAIN = 2'd1,
        PH_HOLD = 2'd2
    } phase_e;

    typedef struct packed {
        logic [HOLD_W-1:0]  hold;
        logic [ERASE_W-1:0] erase;
        logic [PROG_W-1:0]  prog;
        logic [SHORT_W-1:0] short_cnt;
        logic [RWAIT_W-1:0] rwait;
    } timing_t;

    typedef struct packed {
        logic [CNT_W-1:0] main_len;
        logic [CNT_W-1:0] hold_len;
        logic             has_hold;
    } plan_t;

    // Field positions are fixed by the register layout.
    function automatic timing_t unpack_timing(input logic [REG_W-1:0] t0,
                                              input logic [REG_W-1:0] t1,
                                              input logic [REG_W-1:0] t2);
        timing_t r;
        r.rwait     = t0[RWAIT_W-1:0];
        r.hold      = t0[16 +: HOLD_W];
        r.erase     = t1[ERASE_W-1:0];
        r.prog      = t2[PROG_W-1:0];
        r.short_cnt = t2[16 +: SHORT_W];
        return r;
    endfunction

    // A zero count still occupies one cycle.
    function automatic logic [CNT_W-1:0] floor_one(input logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_W'(1) : v;
    endfunction

    function automatic plan_t plan_for(input op_vec_t pick, input timing_t t);
        plan_t p;
        p.hold_len = floor_one(CNT_W'(t.hold));
        p.has_hold = 1'b1;
        if (pick[OPI_RECALL]) begin
            p.main_len = floor_one(CNT_W'(t.short_cnt));
            p.has_hold = 1'b0;
        end else if (pick[OPI_PROG]) begin
            p.main_len = floor_one(CNT_W'(t.prog));
        end else begin
            p.main_len = floor_one(CNT_W'(t.erase));
        end
        return p;
    endfunction

endpackage

// File: rtl/fseq_pick.sv
module fseq_pick
    import flash_seq_pkg::*;
#(
    parameter int N = NUM_OPS
) (
    input  logic         wr,
    input  logic [N-1:0] ops,
    input  logic         busy,
    output logic         accept,
    output logic [N-1:0] pick
);
    // Lowest index has priority.
    for (genvar i = 0; i < N; i++) begin : g_prio
        if (i == 0) begin : g_first
            assign pick[i] = ops[i];
        end else begin : g_rest
            assign pick[i] = ops[i] & ~(|ops[i-1:0]);
        end
    end

    assign accept = wr & ~busy & (|ops);
endmodule

// File: rtl/fseq_timer.sv
module fseq_timer
    import flash_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  plan_t  plan,
    output phase_e phase,
    output logic   done
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] hold_q;
    logic             hold_on;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            hold_q  <= '0;
            hold_on <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase   <= PH_MAIN;
                        cnt     <= plan.main_len - CNT_W'(1);
                        hold_q  <= plan.hold_len;
                        hold_on <= plan.has_hold;
                    end
                end
                PH_MAIN: begin
                    if (cnt == '0) begin
                        if (hold_on) begin
                            phase <= PH_HOLD;
                            cnt   <= hold_q - CNT_W'(1);
                        end else begin
                            phase <= PH_IDLE;
                            done  <= 1'b1;
                        end
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                PH_HOLD: begin
                    if (cnt == '0) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fseq_strobes.sv
module fseq_strobes
    import flash_seq_pkg::*;
#(
    parameter int N = NUM_OPS
) (
    input  phase_e       phase,
    input  logic [N-1:0] op_q,
    input  logic         done,
    output logic [N-1:0] active,
    output logic [N-1:0] clear,
    output logic         main_en,
    output logic         hold_en
);
    logic running;
    assign running = (phase != PH_IDLE);
    assign main_en = (phase == PH_MAIN);
    assign hold_en = (phase == PH_HOLD);

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign active[i] = op_q[i] & running;
        assign clear[i]  = op_q[i] & done;
    end
endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int PAGE_BYTES = 4096,
    localparam int PAGE_SHIFT = $clog2(PAGE_BYTES),
    localparam int PAGE_W     = ADDR_W - PAGE_SHIFT
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ctl_wr,
    input  logic [NUM_OPS-1:0]   ctl_ops,
    input  logic [REG_W-1:0]     tim0,
    input  logic [REG_W-1:0]     tim1,
    input  logic [REG_W-1:0]     tim2,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 redun_dis,
    input  logic                 discharged,
    input  logic                 brownout,
    output logic [4:0]           status,
    output logic [NUM_OPS-1:0]   op_active,
    output logic                 main_en,
    output logic                 hold_en,
    output logic [NUM_OPS-1:0]   op_clear,
    output logic [PAGE_W-1:0]    page_idx,
    output logic [RWAIT_W-1:0]   read_wait
);
    timing_t tm;
    plan_t   plan;
    op_vec_t pick;
    op_vec_t op_q;
    logic    accept;
    logic    busy;
    logic    done;
    phase_e  phase;
    logic [PAGE_W-1:0] page_q;

    assign tm        = unpack_timing(tim0, tim1, tim2);
    assign plan      = plan_for(pick, tm);
    assign busy      = (phase != PH_IDLE);
    assign read_wait = tm.rwait;

    fseq_pick #(.N(NUM_OPS)) i_pick (
        .wr     (ctl_wr),
        .ops    (ctl_ops),
        .busy   (busy),
        .accept (accept),
        .pick   (pick)
    );

    fseq_timer i_timer (
        .clk   (clk),
        .rst   (rst),
        .start (accept),
        .plan  (plan),
        .phase (phase),
        .done  (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= '0;
            page_q <= '0;
        end else if (accept) begin
            op_q   <= pick;
            page_q <= addr[ADDR_W-1:PAGE_SHIFT];
        end
    end

    fseq_strobes #(.N(NUM_OPS)) i_strobes (
        .phase   (phase),
        .op_q    (op_q),
        .done    (done),
        .active  (op_active),
        .clear   (op_clear),
        .main_en (main_en),
        .hold_en (hold_en)
    );

    assign page_idx = page_q;
    assign status   = {brownout, discharged, redun_dis, 1'b0, busy};

    logic unused_bits;
    assign unused_bits = ^{tim0[15:RWAIT_W], tim1[REG_W-1:ERASE_W],
                           tim2[REG_W-1:24], addr[PAGE_SHIFT-1:0]};
endmodule

// File: rtl/flash_op_seq_chk.sv
module flash_op_seq_chk
    import flash_seq_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               ctl_wr,
    input logic [NUM_OPS-1:0] ctl_ops,
    input logic [4:0]         status,
    input logic [NUM_OPS-1:0] op_active,
    input logic               main_en,
    input logic               hold_en,
    input logic [NUM_OPS-1:0] op_clear
);
    p_busy_phase_r12: assert property (@(posedge clk) disable iff (rst)
        status[0] == (main_en | hold_en));

    p_active_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(op_active) && (status[0] == (op_active != '0)));

    p_phase_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(main_en && hold_en));

    p_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && (ctl_ops != '0) && !status[0]) |=> status[0]);

    p_ignore_busy_r8: assert property (@(posedge clk) disable iff (rst)
        status[0] |=> (!status[0] || $stable(op_active)));

    p_clear_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(status[0]) |-> $onehot(op_clear));

    p_clear_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (op_clear != '0) |-> !status[0]);

    p_hold_follows_main_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_en) |-> $past(main_en));

    p_recall_no_hold_r6: assert property (@(posedge clk) disable iff (rst)
        op_active[OPI_RECALL] |-> !hold_en);
endmodule

bind flash_op_seq flash_op_seq_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .ctl_wr    (ctl_wr),
    .ctl_ops   (ctl_ops),
    .status    (status),
    .op_active (op_active),
    .main_en   (main_en),
    .hold_en   (hold_en),
    .op_clear  (op_clear)
);

// File: tb/test_flash_op_seq.sv
module test_flash_op_seq;
    localparam int ADDR_W = 20;
    localparam int PAGE_W = ADDR_W - 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ctl_wr = 1'b0;
    logic [4:0] ctl_ops = '0;
    logic [31:0] tim0 = '0, tim1 = '0, tim2 = '0;
    logic [ADDR_W-1:0] addr = '0;
    logic redun_dis = 1'b0, discharged = 1'b0, brownout = 1'b0;
    logic [4:0] status, op_active, op_clear;
    logic main_en, hold_en;
    logic [PAGE_W-1:0] page_idx;
    logic [5:0] read_wait;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    flash_op_seq #(.ADDR_W(ADDR_W)) i_flash_op_seq (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_ops(ctl_ops),
        .tim0(tim0), .tim1(tim1), .tim2(tim2), .addr(addr),
        .redun_dis(redun_dis), .discharged(discharged), .brownout(brownout),
        .status(status), .op_active(op_active), .main_en(main_en),
        .hold_en(hold_en), .op_clear(op_clear), .page_idx(page_idx),
        .read_wait(read_wait)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int floor1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic logic [4:0] exp_pick(input logic [4:0] ops);
        for (int i = 0; i < 5; i++) if (ops[i]) return 5'(1 << i);
        return 5'd0;
    endfunction

    function automatic int exp_main(input logic [4:0] p, input logic [31:0] t1, input logic [31:0] t2);
        if (p[4]) return floor1(int'(t2[23:16]));
        if (p[2]) return floor1(int'(t2[15:0]));
        return floor1(int'(t1[23:0]));
    endfunction

    function automatic int exp_hold(input logic [4:0] p, input logic [31:0] t0);
        if (p[4]) return 0;
        return floor1(int'(t0[31:16]));
    endfunction

    task automatic run_op(input string req, input logic [4:0] ops,
                          input logic [31:0] t0, input logic [31:0] t1,
                          input logic [31:0] t2, input logic [ADDR_W-1:0] a,
                          input bit disturb);
        logic [4:0] p;
        int em, eh, nm, nh, n;
        p  = exp_pick(ops);
        em = exp_main(p, t1, t2);
        eh = exp_hold(p, t0);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_ops = ops; tim0 = t0; tim1 = t1; tim2 = t2; addr = a;
        @(negedge clk);
        ctl_wr = 1'b0;
        check({req, " R2 busy"}, 32'(status[0]), 32'd1);
        check({req, " R3 op_active"}, 32'(op_active), 32'(p));
        check({req, " R11 page_idx"}, 32'(page_idx), 32'(a >> 12));
        nm = 0; nh = 0; n = 0;
        while (status[0] === 1'b1 && n < 100000) begin
            if (main_en) nm++;
            if (hold_en) nh++;
            if (op_active !== p) check({req, " R8 op_active stable"}, 32'(op_active), 32'(p));
            n++;
            if (disturb && n == 1) begin
                ctl_wr = 1'b1; ctl_ops = 5'b11111;
                tim0 = 32'h0077_003F; tim1 = 32'h0000_0055; tim2 = 32'h0066_0044;
            end else begin
                ctl_wr = 1'b0;
            end
            @(negedge clk);
        end
        ctl_wr = 1'b0;
        if (n >= 100000) check({req, " busy stuck"}, 32'(n), 32'(em + eh));
        if (p[4]) check({req, " R6 recall main"}, 32'(nm), 32'(em));
        else if (p[2]) check({req, " R4 program main"}, 32'(nm), 32'(em));
        else check({req, " R5 erase main"}, 32'(nm), 32'(em));
        check({req, disturb ? " R9 hold" : " R4 R5 R6 hold"}, 32'(nh), 32'(eh));
        check({req, " R10 clear"}, 32'(op_clear), 32'(p));
        @(negedge clk);
        check({req, " R10 clear one cycle"}, 32'(op_clear), 32'd0);
        check({req, " R8 no restart"}, 32'(status[0]), 32'd0);
        tim0 = t0; tim1 = t1; tim2 = t2;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", 32'(status[0]), 32'd0);
        check("R1 active", 32'(op_active), 32'd0);
        check("R1 strobes", 32'({main_en, hold_en}), 32'd0);
        check("R1 clear", 32'(op_clear), 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // R2 empty write starts nothing
        ctl_wr = 1'b1; ctl_ops = 5'd0;
        @(negedge clk);
        ctl_wr = 1'b0;
        check("R2 empty write", 32'(status[0]), 32'd0);

        // R12 / R13 status and read wait
        redun_dis = 1'b1; discharged = 1'b0; brownout = 1'b1;
        tim0 = 32'hABCD_FF2A;
        @(negedge clk);
        check("R12 status", 32'(status), 32'b10100);
        check("R13 read_wait", 32'(read_wait), 32'h2A);
        redun_dis = 1'b0; discharged = 1'b1; brownout = 1'b0;
        @(negedge clk);
        check("R12 status b", 32'(status), 32'b01000);

        // R7 zero counts
        run_op("R7 prog zero", 5'b00100, 32'h0, 32'h0, 32'h0, 20'h0, 1'b0);
        run_op("R7 recall zero", 5'b10000, 32'h0, 32'h0, 32'h0, 20'h0, 1'b0);
        run_op("R7 mass zero", 5'b00001, 32'h0, 32'h0, 32'h0, 20'h0, 1'b0);

        // R3 priority
        run_op("R3 page wins", 5'b11110, 32'h0003_0000, 32'hFF00_0005, 32'h0009_0007, 20'h3A123, 1'b0);
        run_op("R3 ref wins", 5'b11000, 32'h0002_0000, 32'h0000_0004, 32'h0009_0007, 20'h01000, 1'b0);
        run_op("R6 recall", 5'b10000, 32'h0009_0000, 32'h0000_0011, 32'hF00C_0003, 20'h0, 1'b0);

        // R8 / R9 disturbance while running
        run_op("R8 R9 prog", 5'b00100, 32'h0004_0000, 32'h0000_0020, 32'h0000_0006, 20'h05000, 1'b1);
        run_op("R8 R9 page", 5'b00010, 32'h0005_0000, 32'h0000_0003, 32'h0000_0010, 20'hFF000, 1'b1);

        // Constrained random mix
        for (int k = 0; k < 40; k++) begin
            logic [4:0] ops;
            logic [31:0] t0, t1, t2;
            logic [ADDR_W-1:0] a;
            ops = 5'($urandom_range(1, 31));
            t0  = {16'($urandom_range(0, 30)), 10'($urandom), 6'($urandom)};
            t1  = {8'($urandom), 16'd0, 8'($urandom_range(0, 47))};
            t2  = {8'($urandom), 8'($urandom_range(0, 20)), 16'($urandom_range(0, 47))};
            a   = ADDR_W'($urandom);
            run_op("R4 R5 R6 random", ops, t0, t1, t2, a, bit'(k % 3 == 0 && !ops[4]));
            check("R13 random read_wait", 32'(read_wait), 32'(t0[5:0]));
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule